// File: doc/BRIEF.md
# Multi-Window Address Decoder and Translator

This block sits on the inbound side of a bus bridge. It compares each request address against a small set of address windows. Each window matches on a base page, a page mask and a space type (memory or I/O). For the window that matches, the block produces the outbound address, either translated or passed through, along with two access attributes: prefetch and read-line. Pages are 4 KB, so only address bits 31 to 12 take part in matching and translation. Bits 11 to 0 always pass through unchanged.

There are at most six windows. Window 0 is fixed to the configuration region:
- its base and mask come from parameters;
- it is memory space;
- it never translates;
- it carries no attributes.

Window 1 is always built. Windows 2 to 5 are built only when their bit in a parameter is set. Software, or a configuration block upstream, loads the programmable windows through a one-cycle write port. A lookup is presented with a valid strobe and returns one clock later with a one-hot window indication or a no-hit flag.

Top module: `addr_window_xlat`

## Requirements
- R1: While reset is held and on the first edge after it, rsp_valid, rsp_hit, rsp_miss, rsp_addr, rsp_prefetch and rsp_readline are all zero. Every programmable window resets with a zero mask, so after reset only window 0 can hit.
- R2: A window hits when its mask is nonzero, (addr[31:12] & mask) equals (base & mask), and the request space flag req_io equals the window's space bit (0 = memory, 1 = I/O).
- R3: When several windows hit, the lowest-numbered one wins. rsp_hit is one-hot with bit i meaning window i. rsp_miss is 1 exactly when rsp_hit is zero.
- R4: If the winning window has translation enabled, rsp_addr[31:12] takes each bit from the translation field where the mask bit is 1, and from the request address where the mask bit is 0. rsp_addr[11:0] always equals req_addr[11:0].
- R5: If the winning window has translation disabled, or there is no hit, rsp_addr equals req_addr. Window 0 never translates.
- R6: Window 0 matches base CFG_BASE under mask CFG_MASK, for memory-space requests only.
- R7: A window whose bit in WIN_EN is clear (windows 2 to 5) never hits, and writes to it have no effect. Writes to window 0 also have no effect.
- R8: rsp_prefetch and rsp_readline are the winning window's control bits 1 and 2. Both are 0 on a miss.
- R9: rsp_valid is req_valid delayed by one clock. The response fields belong to the request of the previous cycle, so back-to-back requests give back-to-back responses.
- R10: A write with cfg_we=1 updates window cfg_win, field cfg_sel. The field codes are:
  - 0 = control: bit 0 translate enable, bit 1 prefetch, bit 2 read-line.
  - 1 = base: bits 31:12 are the page, bit 0 is the space flag.
  - 2 = mask: bits 31:12.
  - 3 = translation: bits 31:12.
  
  The write applies to lookups presented in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window field write strobe |
| cfg_win | input | $clog2(NUM_WIN) | Window number to write |
| cfg_sel | input | 2 | Field code: 0 control, 1 base, 2 mask, 3 translation |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Request address |
| req_io | input | 1 | Request space: 0 memory, 1 I/O |
| rsp_valid | output | 1 | Response strobe, one clock after req_valid |
| rsp_hit | output | NUM_WIN | One-hot winning window |
| rsp_miss | output | 1 | No window matched |
| rsp_addr | output | 32 | Translated or passed-through address |
| rsp_prefetch | output | 1 | Prefetch attribute of the winning window |
| rsp_readline | output | 1 | Read-line attribute of the winning window |

## Verification
The hardest case to reach from the ports is overlap. Two or more windows must hit at once, including window 0 together with a programmable window, so that the lowest-index rule and the attribute selection are really tested. Random addresses almost never produce this.

The stimulus therefore does two things. First, directed steps program windows 1 and 2 over the same region and place window 1 on top of the configuration page. Second, the random phase draws each lookup address from the base and mask of a chosen target window and fills only the don't-care bits at random, so hits on one window and on several are both frequent. Random writes also target window 0 and the absent windows 4 and 5, so the writes that must be dropped are exercised throughout the run.

// File: rtl/awx_pkg.sv
package awx_pkg;

  localparam int ADDR_W   = 32;
  localparam int PAGE_LSB = 12;
  localparam int PAGE_W   = ADDR_W - PAGE_LSB;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_BASE = 2'd1,
    FLD_MASK = 2'd2,
    FLD_XLAT = 2'd3
  } fld_e;

  typedef struct packed {
    logic [PAGE_W-1:0] base;
    logic              io;
    logic [PAGE_W-1:0] mask;
    logic [PAGE_W-1:0] xlat;
    logic              xen;
    logic              pf;
    logic              rl;
  } win_cfg_t;

  // Window match: masked compare, nonzero mask, same space
  function automatic logic win_hits(input logic [PAGE_W-1:0] page,
                                    input logic io, input win_cfg_t w);
    return (w.mask != '0) && ((page & w.mask) == (w.base & w.mask)) &&
           (io == w.io);
  endfunction

  // Outbound page: masked bits from the translation field
  function automatic logic [PAGE_W-1:0] win_map(input logic [PAGE_W-1:0] page,
                                                input win_cfg_t w);
    return w.xen ? ((page & ~w.mask) | (w.xlat & w.mask)) : page;
  endfunction

endpackage

// File: rtl/awx_win_regs.sv
module awx_win_regs
  import awx_pkg::*;
#(
  parameter int                  NUM_WIN  = 6,
  parameter logic [NUM_WIN-1:0]  IMPL     = 6'b001111,
  parameter logic [PAGE_W-1:0]   CFG_BASE = 20'hF0000,
  parameter logic [PAGE_W-1:0]   CFG_MASK = 20'hFFFFF
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [$clog2(NUM_WIN)-1:0]   win,
  input  logic [1:0]                   sel,
  input  logic [ADDR_W-1:0]            wdata,
  output win_cfg_t [NUM_WIN-1:0]       cfg_o
);
  localparam int IDX_W = $clog2(NUM_WIN);

  logic unused_wbits;
  assign unused_wbits = ^wdata[PAGE_LSB-1:3];

  fld_e fld;
  assign fld = fld_e'(sel);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    if (i == 0) begin : g_cfg
      assign cfg_o[i] = '{base: CFG_BASE, io: 1'b0, mask: CFG_MASK,
                          xlat: '0, xen: 1'b0, pf: 1'b0, rl: 1'b0};
    end else if (IMPL[i]) begin : g_prog
      win_cfg_t r;
      logic     wr_here;
      assign wr_here = we && (win == IDX_W'(i));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          r <= '0;
        end else if (wr_here) begin
          case (fld)
            FLD_CTRL: begin
              r.xen <= wdata[0];
              r.pf  <= wdata[1];
              r.rl  <= wdata[2];
            end
            FLD_BASE: begin
              r.base <= wdata[ADDR_W-1:PAGE_LSB];
              r.io   <= wdata[0];
            end
            FLD_MASK: r.mask <= wdata[ADDR_W-1:PAGE_LSB];
            default:  r.xlat <= wdata[ADDR_W-1:PAGE_LSB];
          endcase
        end
      end
      assign cfg_o[i] = r;
    end else begin : g_absent
      assign cfg_o[i] = '0;
    end
  end

endmodule

// File: rtl/awx_match.sv
module awx_match
  import awx_pkg::*;
#(
  parameter int                 NUM_WIN = 6,
  parameter logic [NUM_WIN-1:0] IMPL    = 6'b001111
)(
  input  logic [PAGE_W-1:0]               page,
  input  logic                            io,
  input  win_cfg_t [NUM_WIN-1:0]          cfg,
  output logic [NUM_WIN-1:0]              hit_raw,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]  page_map
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign hit_raw[i]  = IMPL[i] && win_hits(page, io, cfg[i]);
    assign page_map[i] = win_map(page, cfg[i]);
  end
endmodule

// File: rtl/awx_pick.sv
module awx_pick #(
  parameter int N = 6
)(
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         none
);
  // isolate lowest set bit
  assign grant = req & (~req + N'(1));
  assign none  = ~|req;
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
  import awx_pkg::*;
#(
  parameter int                 NUM_WIN  = 6,
  parameter logic [NUM_WIN-1:0] WIN_EN   = 6'b001111,
  parameter logic [PAGE_W-1:0]  CFG_BASE = 20'hF0000,
  parameter logic [PAGE_W-1:0]  CFG_MASK = 20'hFFFFF
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(NUM_WIN)-1:0]  cfg_win,
  input  logic [1:0]                  cfg_sel,
  input  logic [31:0]                 cfg_wdata,
  input  logic                        req_valid,
  input  logic [31:0]                 req_addr,
  input  logic                        req_io,
  output logic                        rsp_valid,
  output logic [NUM_WIN-1:0]          rsp_hit,
  output logic                        rsp_miss,
  output logic [31:0]                 rsp_addr,
  output logic                        rsp_prefetch,
  output logic                        rsp_readline
);
  // windows 0 and 1 always exist
  localparam logic [NUM_WIN-1:0] IMPL_WIN = WIN_EN | NUM_WIN'(3);

  win_cfg_t [NUM_WIN-1:0]             win_cfg;
  logic [NUM_WIN-1:0]                 win_hit_raw;
  logic [NUM_WIN-1:0]                 win_grant;
  logic                               win_none;
  logic [NUM_WIN-1:0][PAGE_W-1:0]     win_page;
  logic [PAGE_W-1:0]                  req_page;
  logic [PAGE_W-1:0]                  sel_page;
  logic                               sel_pf;
  logic                               sel_rl;

  assign req_page = req_addr[ADDR_W-1:PAGE_LSB];

  awx_win_regs #(
    .NUM_WIN (NUM_WIN), .IMPL (IMPL_WIN),
    .CFG_BASE(CFG_BASE), .CFG_MASK(CFG_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .win(cfg_win),
    .sel(cfg_sel), .wdata(cfg_wdata), .cfg_o(win_cfg)
  );

  awx_match #(.NUM_WIN(NUM_WIN), .IMPL(IMPL_WIN)) u_match (
    .page(req_page), .io(req_io), .cfg(win_cfg),
    .hit_raw(win_hit_raw), .page_map(win_page)
  );

  awx_pick #(.N(NUM_WIN)) u_pick (
    .req(win_hit_raw), .grant(win_grant), .none(win_none)
  );

  always_comb begin
    sel_page = '0;
    sel_pf   = 1'b0;
    sel_rl   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_grant[i]) begin
        sel_page = sel_page | win_page[i];
        sel_pf   = sel_pf | win_cfg[i].pf;
        sel_rl   = sel_rl | win_cfg[i].rl;
      end
    end
    if (win_none) sel_page = req_page;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= '0;
      rsp_miss     <= 1'b0;
      rsp_addr     <= '0;
      rsp_prefetch <= 1'b0;
      rsp_readline <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= win_grant;
      rsp_miss     <= win_none;
      rsp_addr     <= {sel_page, req_addr[PAGE_LSB-1:0]};
      rsp_prefetch <= sel_pf;
      rsp_readline <= sel_rl;
    end
  end

endmodule

// File: rtl/addr_window_xlat_chk.sv
module addr_window_xlat_chk #(
  parameter int                 NUM_WIN = 6,
  parameter logic [NUM_WIN-1:0] WIN_EN  = 6'b001111
)(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_addr,
  input logic               rsp_valid,
  input logic [NUM_WIN-1:0] rsp_hit,
  input logic               rsp_miss,
  input logic [31:0]        rsp_addr,
  input logic               rsp_prefetch,
  input logic               rsp_readline,
  input logic [NUM_WIN-1:0] win_hit_raw
);
  localparam logic [NUM_WIN-1:0] IMPL = WIN_EN | NUM_WIN'(3);

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !rsp_valid);

  a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0(rsp_hit));

  a_r3_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_miss == (rsp_hit == '0)));

  a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((($past(win_hit_raw) & (rsp_hit - NUM_WIN'(1))) == '0) &&
                   ((rsp_hit & ~$past(win_hit_raw)) == '0)));

  a_r7_absent: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_hit & ~IMPL) == '0));

  a_r8_miss_attr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_miss) |-> (!rsp_prefetch && !rsp_readline));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr[11:0] == $past(req_addr[11:0])));

  a_r5_win0_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit[0]) |-> (rsp_addr == $past(req_addr)));

endmodule

bind addr_window_xlat addr_window_xlat_chk #(
  .NUM_WIN(NUM_WIN), .WIN_EN(WIN_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_addr(rsp_addr), .rsp_prefetch(rsp_prefetch),
  .rsp_readline(rsp_readline), .win_hit_raw(win_hit_raw)
);

// File: tb/addr_window_xlat_tb.sv
module addr_window_xlat_tb;
  localparam int CLK_P = 10;
  localparam int NW    = 6;
  localparam logic [NW-1:0] PRESENT = 6'b001111;
  localparam logic [19:0] CB = 20'hF0000;
  localparam logic [19:0] CM = 20'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_io = 1'b0;
  logic        rsp_valid;
  logic [NW-1:0] rsp_hit;
  logic        rsp_miss;
  logic [31:0] rsp_addr;
  logic        rsp_prefetch;
  logic        rsp_readline;

  int n_chk = 0;
  int n_bad = 0;

  logic [19:0] m_base [NW];
  logic        m_io   [NW];
  logic [19:0] m_mask [NW];
  logic [19:0] m_xlat [NW];
  logic [2:0]  m_ctl  [NW];

  always #(CLK_P/2) clk = ~clk;

  addr_window_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_io(req_io), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_addr(rsp_addr),
    .rsp_prefetch(rsp_prefetch), .rsp_readline(rsp_readline)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {hit, miss, pf, rl, addr}
  function automatic logic [40:0] model(input logic [31:0] a, input logic io);
    logic [5:0]  h;
    logic [31:0] o;
    logic        pf;
    logic        rl;
    int          w;
    h = '0; o = a; pf = 0; rl = 0; w = -1;
    for (int i = 0; i < NW; i++) begin
      if (w < 0 && PRESENT[i] && m_mask[i] != 0 && io == m_io[i]) begin
        bit match;
        match = 1;
        for (int b = 0; b < 20; b++)
          if (m_mask[i][b] && (a[12+b] != m_base[i][b])) match = 0;
        if (match) w = i;
      end
    end
    if (w >= 0) begin
      h[w] = 1'b1;
      pf = m_ctl[w][1];
      rl = m_ctl[w][2];
      if (m_ctl[w][0])
        for (int b = 0; b < 20; b++)
          if (m_mask[w][b]) o[12+b] = m_xlat[w][b];
    end
    return {h, (w < 0), pf, rl, o};
  endfunction

  task automatic wr(input int w, input logic [1:0] f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_win = 3'(w); cfg_sel = f; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (w != 0 && PRESENT[w]) begin
      case (f)
        2'd0: m_ctl[w] = d[2:0];
        2'd1: begin m_base[w] = d[31:12]; m_io[w] = d[0]; end
        2'd2: m_mask[w] = d[31:12];
        default: m_xlat[w] = d[31:12];
      endcase
    end
  endtask

  task automatic setwin(input int w, input logic [31:0] base, input logic io,
                        input logic [19:0] mask, input logic [19:0] xl,
                        input logic [2:0] ctl);
    wr(w, 2'd1, {base[31:12], 11'd0, io});
    wr(w, 2'd2, {mask, 12'd0});
    wr(w, 2'd3, {xl, 12'd0});
    wr(w, 2'd0, {29'd0, ctl});
  endtask

  task automatic lookup(input logic [31:0] a, input logic io, input string tag);
    logic [40:0] e;
    e = model(a, io);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_io = io;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid === 1'b1, {tag, " R9 valid"}, 64'(rsp_valid), 64'd1);
    check({rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr} === e, tag,
          64'({rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr}), 64'(e));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [40:0] ea;
    logic [40:0] eb;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NW; i++) begin
      m_base[i] = 0; m_io[i] = 0; m_mask[i] = 0; m_xlat[i] = 0; m_ctl[i] = 0;
    end
    m_base[0] = CB; m_mask[0] = CM;

    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check({rsp_valid, rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr} == 0,
          "R1 reset outputs",
          64'({rsp_valid, rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 idle after reset", 64'(rsp_valid), 64'd0);

    lookup(32'h1234_5678, 0, "R1 empty windows miss");
    lookup(32'hF000_0ABC, 0, "R6 config hit");
    lookup(32'hF000_0ABC, 1, "R6 config io miss");
    lookup(32'hF000_1000, 0, "R6 config neighbour miss");

    setwin(1, 32'h4000_0000, 0, 20'hFFF00, 20'h80000, 3'b011);
    lookup(32'h4001_2345, 0, "R4 translate prefetch");
    lookup(32'h4011_2345, 0, "R2 outside mask miss");

    setwin(2, 32'h4000_0000, 0, 20'hF0000, 20'h12345, 3'b100);
    lookup(32'h4001_2345, 0, "R3 overlap lowest wins");
    lookup(32'h4800_0FFF, 0, "R5 no translate readline R8");

    setwin(3, 32'h0000_1000, 1, 20'hFFFFF, 20'hABCDE, 3'b001);
    lookup(32'h0000_1004, 1, "R2 io window hit");
    lookup(32'h0000_1004, 0, "R2 space mismatch miss");

    setwin(1, 32'hF000_0000, 0, 20'hFFF00, 20'h00000, 3'b111);
    lookup(32'hF000_0010, 0, "R3 window0 over window1");
    lookup(32'hF000_1010, 0, "R10 window1 rewritten");

    setwin(4, 32'h2000_0000, 0, 20'hFFFFF, 20'h11111, 3'b111);
    lookup(32'h2000_0010, 0, "R7 absent window no hit");
    wr(0, 2'd2, 32'h0);
    wr(0, 2'd1, 32'h5000_0001);
    lookup(32'hF000_0020, 0, "R7 window0 write ignored");

    // R9: back-to-back lookups
    ea = model(32'h4800_0123, 0);
    eb = model(32'hF000_0456, 0);
    @(negedge clk); req_valid = 1; req_addr = 32'h4800_0123; req_io = 0;
    @(negedge clk); req_addr = 32'hF000_0456;
    check(rsp_valid && {rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr} === ea,
          "R9 pipelined first",
          64'({rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr}), 64'(ea));
    @(negedge clk); req_valid = 0;
    check(rsp_valid && {rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr} === eb,
          "R9 pipelined second",
          64'({rsp_hit, rsp_miss, rsp_prefetch, rsp_readline, rsp_addr}), 64'(eb));
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 drops after burst", 64'(rsp_valid), 64'd0);

    // constrained random rounds
    for (int r = 0; r < 40; r++) begin
      for (int w = 0; w < NW; w++) begin
        int n;
        logic [19:0] mk;
        n = $urandom_range(0, 20);
        mk = (n == 20) ? 20'h0 : (20'hFFFFF << n);
        if ($urandom_range(0, 2) == 0)
          setwin(w, $urandom(), ($urandom_range(0, 3) == 0), mk,
                 20'($urandom()), 3'($urandom()));
      end
      for (int k = 0; k < 8; k++) begin
        int t;
        logic [31:0] a;
        logic io;
        t = $urandom_range(0, NW - 1);
        a = $urandom();
        a[31:12] = (m_base[t] & m_mask[t]) | (a[31:12] & ~m_mask[t]);
        io = ($urandom_range(0, 4) == 0) ? 1'($urandom()) : m_io[t];
        if ($urandom_range(0, 7) == 0) a = $urandom();
        lookup(a, io, "R2 R3 R4 R5 R8 R10 random");
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule